// File: doc/BRIEF.md
# Color Subcarrier Phase Synthesizer

This block generates the color subcarrier phase for a composite video encoder. A 32-bit phase accumulator advances by a programmable frequency increment on every pixel-clock enable. Two output phase words come from the accumulator. One adds a burst phase offset and one adds an active-video phase offset. Both feed a sine lookup that sits outside this block.

A timing generator supplies a strobe for the falling edge of horizontal sync and the index of the current field within an eight-field sequence. In master and slave modes the accumulator is realigned to a programmed start phase once per sequence, at the sync edge of the first field. Between realignments it runs freely, apart from a programmable per-line phase step that is added at every sync edge to build the PAL 25 Hz offset term. In genlock mode the realignment is replaced by a per-line load of phase and increment words taken from an incoming-video digitizer. A test input forces the sequence reset at once. The generated reference stays available even when incoming burst is passed straight through elsewhere in the encoder.

Settings are written through a small register port. They are held as pending copies and become active together at the next sync strobe, so a setting never changes in the middle of a line.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: While `rst` is high, and after it is released, the accumulator, all pending and active settings, both phase words and `phase_valid` are zero.
- R2: When `pix_en` is high, the accumulator adds the active frequency increment modulo 2^32. With no enable, sync, sequence reset or genlock load it holds its value.
- R3: `burst_phase` and `video_phase` are bits 31..20 of (accumulator + active burst offset) and (accumulator + active video offset) modulo 2^32. They are registered one clock after the accumulator update. `phase_valid` is `pix_en` delayed by the same two registers.
- R4: A register write (`cfg_addr` 0 increment, 1 start phase, 2 line step, 3 burst offset, 4 video offset) has no effect on the outputs until the next `hsync_fall` strobe. At that strobe all pending values become active together.
- R5: In master (`mode` 0) or slave (`mode` 1) mode, an `hsync_fall` with `field_idx` equal to 0 loads the accumulator with the start phase committed at that strobe, overriding the increment and the line step. A strobe in any other field does not load the start phase.
- R6: Every `hsync_fall` that does not realign adds the line step that was active before the strobe, on top of any increment from `pix_en`.
- R7: A `seq_reset` pulse loads the active start phase at once, in any field and mode. It takes priority over realignment and free running.
- R8: In genlock mode (`mode` 2), `gl_load` replaces the accumulator with `gl_phase` and the increment with `gl_freq`. Field 0 strobes then do not realign, and sync commits leave the increment unchanged. In other modes `gl_load` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; advances the accumulator |
| hsync_fall | input | 1 | One-cycle strobe at the falling edge of horizontal sync |
| field_idx | input | 3 | Field index within the eight-field sequence; 0 is the first field |
| mode | input | 2 | 0 master, 1 slave, 2 genlock, 3 behaves as master |
| seq_reset | input | 1 | Test strobe that forces the sequence phase reset immediately |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| gl_load | input | 1 | Genlock per-line load strobe |
| gl_phase | input | 32 | Genlock phase word |
| gl_freq | input | 32 | Genlock relative-frequency word |
| burst_phase | output | 12 | Burst subcarrier phase word |
| video_phase | output | 12 | Active-video subcarrier phase word |
| phase_valid | output | 1 | Marks phase words that follow an enabled pixel |

## Verification
The assertions assume that `hsync_fall`, `seq_reset` and `gl_load` are single-cycle strobes and that `pix_en` is low while reset is applied. The delayed-enable check looks two cycles into the past and relies on that second assumption. The bench changes every input shortly after the falling clock edge and returns each strobe to zero before the next edge. It keeps `pix_en` low on the cycles where a realignment or load is to be observed on its own, so that each expected phase comes from a single rule.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    MODE_MASTER  = 2'd0,
    MODE_SLAVE   = 2'd1,
    MODE_GENLOCK = 2'd2,
    MODE_SPARE   = 2'd3
  } scp_mode_e;

  localparam int unsigned REG_FREQ  = 0;
  localparam int unsigned REG_START = 1;
  localparam int unsigned REG_STEP  = 2;
  localparam int unsigned REG_BURST = 3;
  localparam int unsigned REG_VIDEO = 4;
  localparam int unsigned NUM_REGS  = 5;
endpackage

// File: rtl/scp_shadow_regs.sv
module scp_shadow_regs
  import scp_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ACC_W-1:0]  cfg_wdata,
  input  logic              hs_commit,
  input  logic              genlock,
  input  logic              gl_load_eff,
  input  logic [ACC_W-1:0]  gl_freq,
  output logic [ACC_W-1:0]  freq_act,
  output logic [ACC_W-1:0]  start_act,
  output logic [ACC_W-1:0]  start_next,
  output logic [ACC_W-1:0]  step_act,
  output logic [ACC_W-1:0]  burst_off,
  output logic [ACC_W-1:0]  video_off
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [ACC_W-1:0] pend_q;
    logic [ACC_W-1:0] act_q;

    always_ff @(posedge clk) begin
      if (rst)
        pend_q <= '0;
      else if (cfg_we && (cfg_addr == ADDR_W'(g)))
        pend_q <= cfg_wdata;
    end

    if (g == REG_FREQ) begin : g_freq
      // increment is owned by the genlock loads while in genlock mode
      always_ff @(posedge clk) begin
        if (rst)
          act_q <= '0;
        else if (gl_load_eff)
          act_q <= gl_freq;
        else if (hs_commit && !genlock)
          act_q <= pend_q;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          act_q <= '0;
        else if (hs_commit)
          act_q <= pend_q;
      end
    end
  end

  assign freq_act   = g_reg[REG_FREQ].act_q;
  assign start_act  = g_reg[REG_START].act_q;
  assign step_act   = g_reg[REG_STEP].act_q;
  assign burst_off  = g_reg[REG_BURST].act_q;
  assign video_off  = g_reg[REG_VIDEO].act_q;
  // start phase as it stands after a commit in this cycle
  assign start_next = hs_commit ? g_reg[REG_START].pend_q : g_reg[REG_START].act_q;

  // R4: active increment only moves at a sync strobe or genlock load
  a_r4_freq_hold: assert property (@(posedge clk) disable iff (rst)
    !(hs_commit || gl_load_eff) |=> $stable(freq_act));

  // R8: genlock load takes the supplied increment
  a_r8_gl_freq: assert property (@(posedge clk) disable iff (rst)
    gl_load_eff |=> freq_act == $past(gl_freq));

endmodule

// File: rtl/scp_phase_acc.sv
module scp_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             hs,
  input  logic             realign,
  input  logic             seq_reset,
  input  logic             gl_load_eff,
  input  logic [ACC_W-1:0] gl_phase,
  input  logic [ACC_W-1:0] freq_act,
  input  logic [ACC_W-1:0] step_act,
  input  logic [ACC_W-1:0] start_act,
  input  logic [ACC_W-1:0] start_next,
  output logic [ACC_W-1:0] acc_q,
  output logic             upd_q
);

  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    inc = (pix_en ? freq_act : '0) + (hs ? step_act : '0);
    if (gl_load_eff)
      acc_d = gl_phase;
    else if (seq_reset)
      acc_d = start_act;
    else if (realign)
      acc_d = start_next;
    else
      acc_d = acc_q + inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      upd_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      upd_q <= pix_en;
    end
  end

  // R2: no event, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(pix_en || hs || seq_reset || gl_load_eff) |=> $stable(acc_q));

  // R2: plain enabled step advances by the active increment
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !hs && !seq_reset && !gl_load_eff)
    |=> acc_q == $past(acc_q) + $past(freq_act));

  // R5: first-field sync realignment
  a_r5_realign: assert property (@(posedge clk) disable iff (rst)
    (realign && !seq_reset && !gl_load_eff) |=> acc_q == $past(start_next));

  // R7: forced sequence reset
  a_r7_seq_reset: assert property (@(posedge clk) disable iff (rst)
    (seq_reset && !gl_load_eff) |=> acc_q == $past(start_act));

  // R8: genlock phase load
  a_r8_gl_phase: assert property (@(posedge clk) disable iff (rst)
    gl_load_eff |=> acc_q == $past(gl_phase));

endmodule

// File: rtl/scp_phase_out.sv
module scp_phase_out #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc,
  input  logic             upd,
  input  logic [ACC_W-1:0] burst_off,
  input  logic [ACC_W-1:0] video_off,
  output logic [OUT_W-1:0] burst_phase,
  output logic [OUT_W-1:0] video_phase,
  output logic             valid
);

  localparam int unsigned LSB = ACC_W - OUT_W;

  logic [OUT_W-1:0] burst_d;
  logic [OUT_W-1:0] video_d;

  assign burst_d = OUT_W'((acc + burst_off) >> LSB);
  assign video_d = OUT_W'((acc + video_off) >> LSB);

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_phase <= '0;
      video_phase <= '0;
      valid       <= 1'b0;
    end else begin
      burst_phase <= burst_d;
      video_phase <= video_d;
      valid       <= upd;
    end
  end

  // R3: with equal offsets both words coincide one cycle later
  a_r3_equal_offsets: assert property (@(posedge clk) disable iff (rst)
    (burst_off == video_off) |=> burst_phase == video_phase);

endmodule

// File: rtl/subcarrier_phase_gen.sv
module subcarrier_phase_gen
  import scp_pkg::*;
#(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned OUT_W   = 12,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic               hsync_fall,
  input  logic [FIELD_W-1:0] field_idx,
  input  logic [1:0]         mode,
  input  logic               seq_reset,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [ACC_W-1:0]   cfg_wdata,
  input  logic               gl_load,
  input  logic [ACC_W-1:0]   gl_phase,
  input  logic [ACC_W-1:0]   gl_freq,
  output logic [OUT_W-1:0]   burst_phase,
  output logic [OUT_W-1:0]   video_phase,
  output logic               phase_valid
);

  scp_mode_e        mode_e;
  logic             genlock;
  logic             gl_load_eff;
  logic             realign;
  logic [ACC_W-1:0] freq_act, start_act, start_next, step_act, burst_off, video_off;
  logic [ACC_W-1:0] acc_q;
  logic             upd_q;

  assign mode_e      = scp_mode_e'(mode);
  assign genlock     = (mode_e == MODE_GENLOCK);
  assign gl_load_eff = genlock && gl_load;
  assign realign     = !genlock && hsync_fall && (field_idx == '0);

  scp_shadow_regs #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .hs_commit  (hsync_fall),
    .genlock    (genlock),
    .gl_load_eff(gl_load_eff),
    .gl_freq    (gl_freq),
    .freq_act   (freq_act),
    .start_act  (start_act),
    .start_next (start_next),
    .step_act   (step_act),
    .burst_off  (burst_off),
    .video_off  (video_off)
  );

  scp_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .hs         (hsync_fall),
    .realign    (realign),
    .seq_reset  (seq_reset),
    .gl_load_eff(gl_load_eff),
    .gl_phase   (gl_phase),
    .freq_act   (freq_act),
    .step_act   (step_act),
    .start_act  (start_act),
    .start_next (start_next),
    .acc_q      (acc_q),
    .upd_q      (upd_q)
  );

  scp_phase_out #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc_q),
    .upd        (upd_q),
    .burst_off  (burst_off),
    .video_off  (video_off),
    .burst_phase(burst_phase),
    .video_phase(video_phase),
    .valid      (phase_valid)
  );

  // R3: valid trails the enable by two registers
  a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> $past(pix_en, 2));

  // R1: reset clears the flag on the next edge
  a_r1_reset_valid: assert property (@(posedge clk)
    rst |=> !phase_valid);

endmodule

// File: tb/subcarrier_phase_gen_bench.sv
module subcarrier_phase_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, pix_en, hsync_fall, seq_reset, cfg_we, gl_load;
  logic [2:0]  field_idx, cfg_addr;
  logic [1:0]  mode;
  logic [31:0] cfg_wdata, gl_phase, gl_freq;
  logic [11:0] burst_phase, video_phase;
  logic        phase_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subcarrier_phase_gen u_subcarrier_phase_gen (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hsync_fall(hsync_fall),
    .field_idx(field_idx), .mode(mode), .seq_reset(seq_reset),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .gl_load(gl_load), .gl_phase(gl_phase), .gl_freq(gl_freq),
    .burst_phase(burst_phase), .video_phase(video_phase),
    .phase_valid(phase_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pix_en = 0; hsync_fall = 0; seq_reset = 0; cfg_we = 0; gl_load = 0;
  endtask

  task automatic tick(input logic pe, input logic hs, input logic [2:0] fld);
    pix_en = pe; hsync_fall = hs; field_idx = fld;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; idle(); mode = 2'd0; field_idx = 0; cfg_addr = 0;
    cfg_wdata = 0; gl_phase = 0; gl_freq = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    check("R1 burst", {20'd0, burst_phase}, 32'h0);
    check("R1 video", {20'd0, video_phase}, 32'h0);
    check("R1 valid", {31'd0, phase_valid}, 32'h0);
  endtask

  task automatic t_pending_writes();
    wr(3'd0, 32'h0010_0000);
    wr(3'd1, 32'h1230_0000);
    wr(3'd3, 32'h0800_0000);
    wr(3'd4, 32'h4000_0000);
    repeat (3) tick(1, 0, 3'd2);
    settle();
    check("R4 burst before sync", {20'd0, burst_phase}, 32'h0);
    check("R4 video before sync", {20'd0, video_phase}, 32'h0);
  endtask

  task automatic t_realign_and_run();
    tick(0, 1, 3'd0);
    settle();
    check("R5 burst after field0 sync", {20'd0, burst_phase}, 32'h1A3);
    check("R5 video after field0 sync", {20'd0, video_phase}, 32'h523);
    repeat (5) tick(1, 0, 3'd0);
    settle();
    check("R2 burst after 5 steps", {20'd0, burst_phase}, 32'h1A8);
    check("R3 video after 5 steps", {20'd0, video_phase}, 32'h528);
    check("R3 valid high", {31'd0, phase_valid}, 32'h1);
    settle();
    check("R3 valid low", {31'd0, phase_valid}, 32'h0);
  endtask

  task automatic t_other_field();
    tick(0, 1, 3'd3);
    settle();
    check("R5 no realign field3", {20'd0, burst_phase}, 32'h1A8);
  endtask

  task automatic t_line_step();
    wr(3'd2, 32'h0030_0000);
    tick(0, 1, 3'd2);
    settle();
    check("R6 old step zero", {20'd0, burst_phase}, 32'h1A8);
    tick(1, 1, 3'd5);
    settle();
    check("R6 step plus increment", {20'd0, burst_phase}, 32'h1AC);
  endtask

  task automatic t_slave_realign();
    mode = 2'd1;
    tick(0, 1, 3'd0);
    settle();
    check("R5 slave realign", {20'd0, burst_phase}, 32'h1A3);
  endtask

  task automatic t_wrap();
    wr(3'd1, 32'hFFF0_0000);
    tick(0, 1, 3'd0);
    settle();
    check("R5 new start burst", {20'd0, burst_phase}, 32'h07F);
    check("R3 new start video", {20'd0, video_phase}, 32'h3FF);
    tick(1, 0, 3'd1);
    settle();
    check("R2 wrap burst", {20'd0, burst_phase}, 32'h080);
    check("R2 wrap video", {20'd0, video_phase}, 32'h400);
  endtask

  task automatic t_seq_reset();
    repeat (2) tick(1, 0, 3'd4);
    settle();
    check("R2 before seq reset", {20'd0, burst_phase}, 32'h082);
    seq_reset = 1; field_idx = 3'd4;
    @(negedge clk);
    idle();
    settle();
    check("R7 seq reset burst", {20'd0, burst_phase}, 32'h07F);
  endtask

  task automatic t_genlock();
    mode = 2'd2;
    gl_load = 1; gl_phase = 32'h5000_0000; gl_freq = 32'h0020_0000;
    @(negedge clk);
    idle();
    settle();
    check("R8 gl phase", {20'd0, burst_phase}, 32'h580);
    repeat (2) tick(1, 0, 3'd1);
    settle();
    check("R8 gl freq", {20'd0, burst_phase}, 32'h584);
    tick(0, 1, 3'd0);
    settle();
    check("R8 no realign, R6 step", {20'd0, burst_phase}, 32'h587);
    tick(1, 0, 3'd0);
    settle();
    check("R8 freq kept over sync", {20'd0, burst_phase}, 32'h589);
    check("R8 video", {20'd0, video_phase}, 32'h909);
    mode = 2'd0;
    gl_load = 1; gl_phase = 32'h0; gl_freq = 32'h0;
    @(negedge clk);
    idle();
    settle();
    check("R8 load ignored in master", {20'd0, burst_phase}, 32'h589);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_pending_writes();
    t_realign_and_run();
    t_other_field();
    t_line_step();
    t_slave_realign();
    t_wrap();
    t_seq_reset();
    t_genlock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule